// File: doc/BRIEF.md
# Always-On Register Shadow Update Sequencer

The sequencer sits between the fast, bus-side copies of eight always-on registers and their copies in a slow, persistent domain. A bus write lands in the bus-side copy at once and marks that register as pending. On each pulse of a slow-domain enable strobe, which stands in for the slow clock, the block moves one pending register across. It always chooses the lowest pending index. Indices 0 to 5 are the six persistent registers, index 6 is the alarm and index 7 is the seconds counter, so a seconds write is the last one applied in any batch.

Software sees two 8-bit masks in a 32-bit status word. The pending mask is in bits 23:16, with register i at bit 16+i. After writing the seconds register, software polls bit 23 until it clears. The refreshed mask is in bits 15:8, with register i at bit 8+i. It marks the register that the most recent strobe copied. Two things start a transfer without a fresh value. The force input marks registers pending on its own. A write to register 1 with bit 31 set asks for a full refresh of all eight registers, for example to apply a new watchdog setting.

Top module: `shreg_sequencer`

## Requirements
- R1: A bus write to index i (0..7) sets status bit 16+i from the clock edge that accepts the write, whatever the state of the strobe.
- R2: A strobe cycle copies at most one register. It takes the lowest index whose pending bit is set, moves that register's bus-side value into its slow copy, and clears the pending bit. Slow copies change only in strobe cycles.
- R3: The refreshed mask (status bits 15:8) takes a one-hot value for the register copied by a strobe. It holds that value until the next strobe and reads zero after a strobe that finds nothing pending.
- R4: Two or more writes to a register while it is still pending cause exactly one transfer, and that transfer carries the newest value.
- R5: A write to register i in the same cycle as the strobe that copies i is queued again. The slow copy takes the previous value, bit 16+i stays set, and a later strobe copies the new value.
- R6: A force-mask bit i sets pending bit i without a bus write. The following transfer copies the existing bus-side value unchanged.
- R7: A write to index 1 with bit 31 set marks all eight registers pending. The next eight strobes refresh indices 0 through 7 in ascending order.
- R8: Synchronous reset clears both masks and sets all bus-side and slow copies to zero.
- R9: Status bits 31:24 and 7:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_idx | input | 3 | Register index written |
| wr_data | input | 32 | Write data |
| force_mask | input | 8 | Marks registers pending without a write |
| slow_tick | input | 1 | One-cycle slow-domain enable strobe |
| status | output | 32 | Pending mask in 23:16, refreshed mask in 15:8 |
| slow_flat | output | 256 | Slow copies; register i in bits 32*i+31 to 32*i |

## Verification
Assertions check several rules on every cycle. The refreshed mask is never more than one-hot, and it moves only on a strobe. A strobe that finds pending work picks a register that was pending, with no lower pending index below it. Any set request is visible in the pending mask on the next cycle, and slow copies stay still between strobes. Some behaviour only the bench scenarios can show, because it depends on values across several cycles. These are: the newest value winning after repeated writes, a single transfer for a doubly written register, the same-cycle re-queue case, force transfers carrying unchanged data, and the full eight-step refresh in index order.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NREG      = 8;
  localparam int unsigned IDX_W     = $clog2(NREG);
  localparam int unsigned STALE_LSB = 16;
  localparam int unsigned FRESH_LSB = 8;
  localparam int unsigned FORCE_REG = 1;
  localparam int unsigned FORCE_BIT = 31;
endpackage

// File: rtl/shreg_bus_store.sv
module shreg_bus_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 8,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/shreg_pick.sv
module shreg_pick #(
  parameter int unsigned NREG   = 8,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  req,
  output logic [NREG-1:0]  grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any
);
  logic [NREG:0] lower;
  assign lower[0] = 1'b0;

  for (genvar g = 0; g < NREG; g++) begin : g_chain
    assign lower[g+1] = lower[g] | req[g];
    assign grant[g]   = req[g] & ~lower[g];
  end

  assign any = lower[NREG];

  always_comb begin
    grant_idx = '0;
    for (int k = 0; k < NREG; k++) begin
      if (grant[k]) grant_idx = grant_idx | IDX_W'(k);
    end
  end
endmodule

// File: rtl/shreg_flags.sv
module shreg_flags #(
  parameter int unsigned NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [NREG-1:0] grant,
  input  logic [NREG-1:0] set_mask,
  output logic [NREG-1:0] stale_q,
  output logic [NREG-1:0] fresh_q
);
  logic [NREG-1:0] clr_mask;
  assign clr_mask = tick ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stale_q <= '0;
      fresh_q <= '0;
    end else begin
      stale_q <= (stale_q & ~clr_mask) | set_mask;
      if (tick) fresh_q <= grant;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (stale_q == '0 && fresh_q == '0)); // R8
  AST_FRESH_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(fresh_q)); // R3
  AST_FRESH_HOLDS: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(fresh_q)); // R3
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (tick && (stale_q != '0)) |=> (fresh_q != '0) && ((fresh_q & $past(stale_q)) == fresh_q)
      && (((fresh_q - NREG'(1)) & $past(stale_q)) == '0)); // R2
  AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (set_mask != '0) |=> ((stale_q & $past(set_mask)) == $past(set_mask))); // R1
endmodule

// File: rtl/shreg_slow_bank.sv
module shreg_slow_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic [NREG-1:0]        grant,
  input  logic [DATA_W-1:0]      din,
  output logic [NREG*DATA_W-1:0] slow_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (tick && grant[g]) q <= din;
    end
    assign slow_flat[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/shreg_sequencer.sv
module shreg_sequencer
  import shreg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NREG-1:0]        force_mask,
  input  logic                   slow_tick,
  output logic [31:0]            status,
  output logic [NREG*DATA_W-1:0] slow_flat
);
  logic [NREG-1:0]   stale_q, fresh_q, grant, wr_mask, set_mask;
  logic [IDX_W-1:0]  grant_idx;
  logic              any_stale, full_refresh;
  logic [DATA_W-1:0] copy_data;

  assign wr_mask      = wr_en ? (NREG'(1) << wr_idx) : '0;
  assign full_refresh = wr_en && (wr_idx == IDX_W'(FORCE_REG)) && wr_data[FORCE_BIT];
  assign set_mask     = wr_mask | force_mask | {NREG{full_refresh}};

  shreg_bus_store #(.DATA_W(DATA_W), .NREG(NREG)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
    .raddr(grant_idx), .rdata(copy_data)
  );

  shreg_pick #(.NREG(NREG)) u_pick (
    .req(stale_q), .grant(grant), .grant_idx(grant_idx), .any(any_stale)
  );

  shreg_flags #(.NREG(NREG)) u_flags (
    .clk(clk), .rst(rst), .tick(slow_tick), .grant(grant),
    .set_mask(set_mask), .stale_q(stale_q), .fresh_q(fresh_q)
  );

  shreg_slow_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_slow (
    .clk(clk), .rst(rst), .tick(slow_tick), .grant(grant),
    .din(copy_data), .slow_flat(slow_flat)
  );

  always_comb begin
    status = '0;
    status[STALE_LSB +: NREG] = stale_q;
    status[FRESH_LSB +: NREG] = fresh_q;
  end

  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> status[STALE_LSB + 32'($past(wr_idx))]); // R1
  AST_SLOW_STILL: assert property (@(posedge clk) disable iff (rst)
    !slow_tick |=> $stable(slow_flat)); // R2
  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (rst)
    (slow_tick && !any_stale) |=> (status[FRESH_LSB +: NREG] == '0)); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk)
    (status[31:24] == 8'h00) && (status[7:0] == 8'h00)); // R9
endmodule

// File: tb/sim_shreg_sequencer.sv
module sim_shreg_sequencer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_idx = '0;
  logic [31:0]  wr_data = '0;
  logic [7:0]   force_mask = '0;
  logic         slow_tick = 1'b0;
  logic [31:0]  status;
  logic [255:0] slow_flat;

  int compared = 0, mismatched = 0;
  string cur_req = "R8";

  logic [31:0] m_bus [8];
  logic [31:0] m_slow [8];
  logic [7:0]  m_stale = '0, m_new = '0;
  int xfer_cnt [8];

  always #2 clk = ~clk;

  shreg_sequencer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .force_mask(force_mask), .slow_tick(slow_tick), .status(status), .slow_flat(slow_flat)
  );

  // behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 8; k++) begin m_bus[k] = 0; m_slow[k] = 0; xfer_cnt[k] = 0; end
      m_stale = 0; m_new = 0;
    end else begin
      if (slow_tick) begin
        int pick;
        pick = -1;
        for (int k = 7; k >= 0; k--) if (m_stale[k]) pick = k;
        m_new = 0;
        if (pick >= 0) begin
          m_slow[pick] = m_bus[pick];
          m_stale[pick] = 1'b0;
          m_new[pick] = 1'b1;
          xfer_cnt[pick]++;
        end
      end
      if (wr_en) begin
        m_bus[wr_idx] = wr_data;
        m_stale[wr_idx] = 1'b1;
        if (wr_idx == 3'd1 && wr_data[31]) m_stale = 8'hFF;
      end
      m_stale = m_stale | force_mask;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "status", status, {8'h00, m_stale, m_new, 8'h00});
      for (int k = 0; k < 8; k++) check(cur_req, "slow copy", slow_flat[32*k +: 32], m_slow[k]);
    end
  end

  task automatic cyc(input logic w, input int idx, input logic [31:0] d,
                     input logic [7:0] f, input logic t);
    wr_en = w; wr_idx = 3'(idx); wr_data = d; force_mask = f; slow_tick = t;
    @(negedge clk);
    wr_en = 0; force_mask = 0; slow_tick = 0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0); end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R8";
    check("R8", "reset status", status, 32'h0);
    check("R8", "reset slow7", slow_flat[255:224], 32'h0);

    cur_req = "R1";
    cyc(1, 7, 32'h1234_5678, 0, 0);
    check("R1", "seconds pending bit", {31'b0, status[23]}, 32'h1);
    cur_req = "R3";
    tick_n(1);
    check("R2", "seconds copied", slow_flat[255:224], 32'h1234_5678);
    check("R3", "fresh mask", status[15:8], 32'h80);
    tick_n(1);
    check("R3", "fresh after idle tick", status[15:8], 32'h0);

    cur_req = "R2";
    cyc(1, 5, 32'h5555, 0, 0);
    cyc(1, 2, 32'h2222, 0, 0);
    cyc(1, 6, 32'h6666, 0, 0);
    check("R1", "three pending", status[23:16], 32'h64);
    tick_n(1); check("R2", "order step1", status[15:8], 32'h04);
    tick_n(1); check("R2", "order step2", status[15:8], 32'h20);
    tick_n(1); check("R2", "order step3", status[15:8], 32'h40);

    cur_req = "R4";
    cyc(1, 3, 32'hAAAA, 0, 0);
    cyc(1, 3, 32'hBBBB, 0, 0);
    tick_n(3);
    check("R4", "newest value", slow_flat[127:96], 32'hBBBB);
    check("R4", "single transfer", 32'(xfer_cnt[3]), 32'd1);

    cur_req = "R5";
    cyc(1, 0, 32'h0101, 0, 0);
    cyc(1, 0, 32'h0202, 0, 1);
    check("R5", "old value copied", slow_flat[31:0], 32'h0101);
    check("R5", "still pending", {31'b0, status[16]}, 32'h1);
    tick_n(1);
    check("R5", "new value later", slow_flat[31:0], 32'h0202);

    cur_req = "R6";
    cyc(0, 0, 0, 8'h84, 0);
    check("R6", "forced pending", status[23:16], 32'h84);
    tick_n(2);
    check("R6", "force keeps reg2", slow_flat[95:64], 32'h2222);
    check("R6", "force keeps reg7", slow_flat[255:224], 32'h1234_5678);

    cur_req = "R7";
    cyc(1, 1, 32'h8000_0011, 0, 0);
    check("R7", "all pending", status[23:16], 32'hFF);
    for (int k = 0; k < 8; k++) begin
      tick_n(1);
      check("R7", "refresh order", status[15:8], 32'(8'h01 << k));
    end
    check("R7", "reg1 copied", slow_flat[63:32], 32'h8000_0011);

    cur_req = "R9";
    check("R9", "reserved bits", {status[31:24], status[7:0]}, 32'h0);

    cur_req = "R8";
    cyc(1, 4, 32'h4444, 0, 0);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check("R8", "status after reset", status, 32'h0);
    check("R8", "slow4 after reset", slow_flat[159:128], 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule